// File: doc/BRIEF.md
# Wait-State Bus Memory Subordinate

This block is a subordinate on a pipelined 32-bit system bus. It holds a small on-chip word memory. When the decoder selects it, it captures the address-phase control of a transfer and serves that transfer in the following data phase. Reads and writes of one byte, one halfword or one full word are placed on the correct little-endian byte lanes. Writes and reads use separate data buses, so no tri-state drivers are needed. Bursts are treated as a series of independent beats.

Every accepted access stretches its data phase by a fixed number of wait states, set by a parameter. During each wait state the block drives readyout low with an okay response. The bus is its only flow control. A new address phase is accepted only while the bus ready input is high. While readyout is low, the manager must hold its next address, and whatever is on the address and control inputs is disregarded. Accesses that are misaligned, too wide or outside the memory are refused with the two-cycle error response. The memory is not touched in that case.

Top module: `wait_mem_sub`

## Requirements
- R1: An access is captured only on a clock edge where sel_i and ready_i are both high and trans_i is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) or BUSY (2'b01) while selected, or any trans_i while unselected, gives readyout_o high with resp_o okay in the next cycle and leaves the memory unchanged. Address and control presented while ready_i is low are ignored.
- R2: For an accepted, valid access, readyout_o is low with resp_o okay (2'b00) for exactly WAIT_STATES cycles after the address phase, then high for one cycle, which ends the transfer.
- R3: A write stores wdata_i from the final data-phase cycle into the lanes selected by the captured size and address. The size codes are 0 = byte, 1 = halfword and 2 = word. A byte at address offset k uses wdata_i[8k+7:8k]. A halfword with address bit 1 equal to h uses wdata_i[16h+15:16h]. A word uses all four lanes. The other bytes of the word are unchanged.
- R4: A read shows the addressed bytes on rdata_o in the final data-phase cycle, on the same lanes as in R3. The inactive lanes are zero.
- R5: A halfword at an odd address, a word whose address is not a multiple of 4, and any size code above 2 are answered with resp_o error (2'b01) and readyout_o low for one cycle, then resp_o error and readyout_o high for one cycle. The memory is not written.
- R6: An access at a byte address of DEPTH_WORDS*4 or above is answered with the R5 error sequence and writes nothing, including to the word its low address bits would alias to.
- R7: While and right after reset, readyout_o is high and resp_o is okay.
- R8: The next address phase is accepted during the final cycle of any data phase, including the second error cycle. A write is visible to a read that follows it immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Select from the address decoder |
| addr_i | input | ADDR_W | Byte address of the address phase |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | Transfer size code: 0 byte, 1 halfword, 2 word |
| trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| wdata_i | input | 32 | Write data bus |
| ready_i | input | 1 | Bus ready: high when the current data phase ends |
| rdata_o | output | 32 | Read data bus, steered to the active lanes |
| readyout_o | output | 1 | Low to extend the data phase |
| resp_o | output | 2 | Response: 00 okay, 01 error |

## Verification
Take an address phase presented before the rising edge that opens cycle N. For a valid access, readyout_o is low in cycles N+1 to N+WAIT_STATES, and the result (read data, or the end of a write) is due in cycle N+WAIT_STATES+1. For a refused access, the error pair is due in cycles N+1 and N+2. An ignored phase must show readyout_o high and okay in cycle N+1. The bench drives and samples only at falling edges. It counts the low-readyout cycles of each data phase until readyout_o rises, compares that count and the response with the value the requirements predict, and checks rdata_o in that same final cycle. During wait cycles it also drives random address and control, to show that they are ignored.

// File: rtl/wms_pkg.sv
package wms_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned LANES = BUS_W / 8;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [1:0] RSP_OKAY = 2'b00;
  localparam logic [1:0] RSP_ERR  = 2'b01;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_ERR1,
    ST_ERR2
  } seq_state_e;

  typedef struct packed {
    logic       wr;
    logic [2:0] size;
    logic [1:0] lane;
  } acc_ctrl_t;

  function automatic logic [LANES-1:0] lane_mask(logic [2:0] size, logic [1:0] off);
    logic [LANES-1:0] m;
    case (size)
      SZ_BYTE: m = 4'b0001 << off;
      SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  function automatic logic is_misaligned(logic [2:0] size, logic [1:0] off);
    logic bad;
    case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = (off != 2'b00);
      default: bad = 1'b1;
    endcase
    return bad;
  endfunction
endpackage

// File: rtl/wms_store.sv
module wms_store
  import wms_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [LANES-1:0] be_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rword_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (be_i[k]) bank[idx_i] <= wdata_i[8*k +: 8];
    end

    assign rword_o[8*k +: 8] = bank[idx_i];
  end
endmodule

// File: rtl/wms_lanes.sv
module wms_lanes
  import wms_pkg::*;
(
  input  logic             fire_i,
  input  acc_ctrl_t        ctrl_i,
  input  logic [BUS_W-1:0] rword_i,
  output logic [LANES-1:0] be_o,
  output logic [BUS_W-1:0] rdata_o
);
  logic [LANES-1:0] mask;

  assign mask = lane_mask(ctrl_i.size, ctrl_i.lane);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be_o[k] = fire_i && ctrl_i.wr && mask[k];
    assign rdata_o[8*k +: 8] = (fire_i && !ctrl_i.wr && mask[k]) ? rword_i[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/wms_seq.sv
module wms_seq
  import wms_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 2,
  localparam int unsigned CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       take_err_i,
  output logic       fire_o,
  output logic       readyout_o,
  output logic [1:0] resp_o
);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_STATES);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_ACT: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else             st_d  = ST_IDLE;
      end
      ST_ERR1: st_d = ST_ERR2;
      ST_ERR2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (take_i) begin
      if (take_err_i) begin
        st_d = ST_ERR1;
      end else begin
        st_d  = ST_ACT;
        cnt_d = WAIT_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign fire_o     = (st_q == ST_ACT) && (cnt_q == '0);
  assign readyout_o = !(((st_q == ST_ACT) && (cnt_q != '0)) || (st_q == ST_ERR1));
  assign resp_o     = ((st_q == ST_ERR1) || (st_q == ST_ERR2)) ? RSP_ERR : RSP_OKAY;
endmodule

// File: rtl/wms_addr_stage.sv
module wms_addr_stage
  import wms_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned BYTES = DEPTH * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              ready_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  output logic              take_o,
  output logic              take_err_o,
  output acc_ctrl_t         ctrl_q,
  output logic [IDX_W-1:0]  idx_q
);
  logic active_type;
  logic out_of_range;

  assign active_type  = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);
  assign out_of_range = (addr_i >= ADDR_W'(BYTES));
  assign take_o       = sel_i && ready_i && active_type;
  assign take_err_o   = take_o && (out_of_range || is_misaligned(size_i, addr_i[1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      idx_q  <= '0;
    end else if (take_o) begin
      ctrl_q.wr   <= write_i;
      ctrl_q.size <= size_i;
      ctrl_q.lane <= addr_i[1:0];
      idx_q       <= addr_i[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/wait_mem_sub.sv
module wait_mem_sub
  import wms_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DEPTH_WORDS = 256,
  parameter int unsigned WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [1:0]        trans_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              ready_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              readyout_o,
  output logic [1:0]        resp_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

  logic             take, take_err, fire;
  acc_ctrl_t        ctrl;
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] be;
  logic [BUS_W-1:0] rword;

  wms_addr_stage #(.ADDR_W(ADDR_W), .DEPTH(DEPTH_WORDS)) addr_i0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .ready_i(ready_i), .trans_i(trans_i),
    .addr_i(addr_i), .write_i(write_i), .size_i(size_i),
    .take_o(take), .take_err_o(take_err), .ctrl_q(ctrl), .idx_q(idx)
  );

  wms_seq #(.WAIT_STATES(WAIT_STATES)) seq_i0 (
    .clk(clk), .rst_n(rst_n), .take_i(take), .take_err_i(take_err),
    .fire_o(fire), .readyout_o(readyout_o), .resp_o(resp_o)
  );

  wms_lanes lanes_i0 (
    .fire_i(fire), .ctrl_i(ctrl), .rword_i(rword), .be_o(be), .rdata_o(rdata_o)
  );

  wms_store #(.DEPTH(DEPTH_WORDS)) store_i0 (
    .clk(clk), .be_i(be), .idx_i(idx), .wdata_i(wdata_i), .rword_o(rword)
  );
endmodule

// File: rtl/wms_checker.sv
module wms_checker
  import wms_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic [1:0] trans_i,
  input logic       ready_i,
  input logic       readyout_o,
  input logic [1:0] resp_o
);
  int unsigned okay_waits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) okay_waits <= 0;
    else if (!readyout_o && (resp_o == RSP_OKAY)) okay_waits <= okay_waits + 1;
    else okay_waits <= 0;
  end

  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !(sel_i && ((trans_i == TR_NONSEQ) || (trans_i == TR_SEQ))))
    |=> (readyout_o && (resp_o == RSP_OKAY)));

  assert_wait_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!readyout_o && (resp_o == RSP_OKAY)) |-> (okay_waits < WAIT_STATES));

  assert_wait_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!readyout_o && (resp_o == RSP_OKAY)) && readyout_o) |-> (okay_waits == WAIT_STATES));

  assert_err_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!readyout_o && (resp_o == RSP_ERR)) |=> (readyout_o && (resp_o == RSP_ERR)));

  assert_err_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && (resp_o == RSP_ERR)) |-> $past(!readyout_o && (resp_o == RSP_ERR)));

  assert_reset_R7: assert property (@(posedge clk)
    !rst_n |=> (readyout_o && (resp_o == RSP_OKAY)));
endmodule

bind wait_mem_sub wms_checker #(.WAIT_STATES(WAIT_STATES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .trans_i(trans_i), .ready_i(ready_i),
  .readyout_o(readyout_o), .resp_o(resp_o)
);

// File: tb/wait_mem_sub_tb_top.sv
module wait_mem_sub_tb_top;
  import wms_pkg::*;

  localparam int unsigned DEPTH = 256;
  localparam int unsigned WAITS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        write_i = 1'b0;
  logic [2:0]  size_i = '0;
  logic [1:0]  trans_i = TR_IDLE;
  logic [31:0] wdata_i = '0;
  logic        ready_i;
  logic [31:0] rdata_o;
  logic        readyout_o;
  logic [1:0]  resp_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [31:0] model [DEPTH];

  assign ready_i = readyout_o;

  always #5 clk = ~clk;

  wait_mem_sub #(.ADDR_W(32), .DEPTH_WORDS(DEPTH), .WAIT_STATES(WAITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .write_i(write_i),
    .size_i(size_i), .trans_i(trans_i), .wdata_i(wdata_i), .ready_i(ready_i),
    .rdata_o(rdata_o), .readyout_o(readyout_o), .resp_o(resp_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit lane_on(int k, int unsigned a, logic [2:0] sz);
    int unsigned off = a % 4;
    int unsigned n = 1 << sz;
    return (k >= int'(off)) && (k < int'(off + n));
  endfunction

  function automatic bit is_bad(int unsigned a, logic [2:0] sz);
    if (a >= DEPTH * 4) return 1'b1;
    if (sz > 3'd2) return 1'b1;
    return (a % (1 << sz)) != 0;
  endfunction

  function automatic logic [31:0] exp_read(int unsigned a, logic [2:0] sz);
    logic [31:0] w = model[a / 4];
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (lane_on(k, a, sz)) r[8*k +: 8] = w[8*k +: 8];
    return r;
  endfunction

  // Call at a falling edge where an address phase may be presented.
  // Returns at the falling edge of the final data-phase cycle.
  task automatic xfer(input int unsigned a, input bit wr, input logic [2:0] sz,
                      input logic [31:0] wd);
    bit bad = is_bad(a, sz);
    bit oor = (a >= DEPTH * 4);
    int waits = 0;
    string rq = oor ? "R6" : (bad ? "R5" : "R2");
    sel_i   = 1'b1;
    trans_i = ($urandom % 2) ? TR_SEQ : TR_NONSEQ;
    addr_i  = a;
    write_i = wr;
    size_i  = sz;
    @(negedge clk);
    wdata_i = wd;
    while (!readyout_o && waits < 64) begin
      check(resp_o == (bad ? RSP_ERR : RSP_OKAY), rq, "resp while stalled",
            {30'd0, resp_o}, {30'd0, bad ? RSP_ERR : RSP_OKAY});
      // R1: control presented while ready is low must be ignored
      sel_i   = 1'b1;
      trans_i = TR_NONSEQ;
      addr_i  = $urandom;
      write_i = 1'($urandom % 2);
      size_i  = 3'($urandom % 3);
      waits++;
      @(negedge clk);
    end
    sel_i   = 1'b0;
    trans_i = TR_IDLE;
    check(waits == (bad ? 1 : int'(WAITS)), rq, "stall cycles", waits, bad ? 1 : WAITS);
    check(resp_o == (bad ? RSP_ERR : RSP_OKAY), rq, "final resp",
          {30'd0, resp_o}, {30'd0, bad ? RSP_ERR : RSP_OKAY});
    if (!bad && !wr) check(rdata_o == exp_read(a, sz), "R4", "read data", rdata_o, exp_read(a, sz));
    if (!bad && wr)
      for (int k = 0; k < 4; k++) if (lane_on(k, a, sz)) model[a / 4][8*k +: 8] = wd[8*k +: 8];
  endtask

  // R1: a phase that must not start an access
  task automatic probe(input int kind);
    sel_i   = (kind != 0);
    trans_i = (kind == 1) ? TR_IDLE : ((kind == 2) ? TR_BUSY : TR_NONSEQ);
    addr_i  = ($urandom % DEPTH) * 4;
    write_i = 1'b1;
    size_i  = SZ_WORD;
    @(negedge clk);
    wdata_i = $urandom;
    check(readyout_o && (resp_o == RSP_OKAY), "R1", "ignored phase response",
          {29'd0, readyout_o, resp_o}, {29'd0, 1'b1, RSP_OKAY});
    sel_i   = 1'b0;
    trans_i = TR_IDLE;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(readyout_o && (resp_o == RSP_OKAY), "R7", "reset outputs",
          {29'd0, readyout_o, resp_o}, {29'd0, 1'b1, RSP_OKAY});
    rst_n = 1'b1;
    @(negedge clk);
    check(readyout_o && (resp_o == RSP_OKAY), "R7", "after reset",
          {29'd0, readyout_o, resp_o}, {29'd0, 1'b1, RSP_OKAY});

    for (int i = 0; i < int'(DEPTH); i++) xfer(i * 4, 1'b1, SZ_WORD, $urandom);

    // Directed lane cases
    xfer(32'h40, 1'b1, SZ_WORD, 32'h11223344);
    xfer(32'h41, 1'b0, SZ_BYTE, 32'h0);
    check(rdata_o == 32'h00003300, "R4", "byte lane 1", rdata_o, 32'h00003300);
    xfer(32'h42, 1'b0, SZ_HALF, 32'h0);
    check(rdata_o == 32'h11220000, "R4", "upper halfword", rdata_o, 32'h11220000);
    xfer(32'h43, 1'b1, SZ_BYTE, 32'hAB5A5A5A);
    xfer(32'h40, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == 32'hAB223344, "R3", "byte write lane 3", rdata_o, 32'hAB223344);
    xfer(32'h40, 1'b1, SZ_HALF, 32'h9999BEEF);
    xfer(32'h40, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == 32'hAB22BEEF, "R3", "halfword write low", rdata_o, 32'hAB22BEEF);

    // Error cases leave memory untouched
    xfer(32'h42, 1'b1, SZ_WORD, 32'hFFFFFFFF);
    xfer(32'h41, 1'b1, SZ_HALF, 32'hFFFFFFFF);
    xfer(32'h40, 1'b1, 3'd3, 32'hFFFFFFFF);
    xfer(32'h40, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == 32'hAB22BEEF, "R5", "no write on error", rdata_o, 32'hAB22BEEF);
    xfer(DEPTH * 4, 1'b1, SZ_WORD, 32'hDEADDEAD);
    xfer(DEPTH * 4 + 64, 1'b1, SZ_WORD, 32'hDEADDEAD);
    xfer(0, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == model[0], "R6", "no aliased write", rdata_o, model[0]);
    xfer(DEPTH * 4 - 4, 1'b0, SZ_WORD, 32'h0);

    // Ignored phases do not write
    probe(1);
    probe(2);
    probe(0);
    xfer(32'h40, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == model[16], "R1", "no write from ignored phases", rdata_o, model[16]);

    // Back-to-back write then read, and accept after error
    xfer(32'h80, 1'b1, SZ_WORD, 32'hCAFEF00D);
    xfer(32'h80, 1'b0, SZ_WORD, 32'h0);
    check(rdata_o == 32'hCAFEF00D, "R8", "write then read", rdata_o, 32'hCAFEF00D);
    xfer(32'h81, 1'b0, SZ_WORD, 32'h0);
    xfer(32'h82, 1'b0, SZ_HALF, 32'h0);
    check(rdata_o == 32'hCAFE0000, "R8", "read right after error", rdata_o, 32'hCAFE0000);

    // Constrained random mix
    for (int n = 0; n < 500; n++) begin
      int unsigned pick = $urandom % 20;
      if (pick < 2) begin
        probe(int'($urandom % 3));
      end else begin
        int unsigned a;
        logic [2:0] sz;
        if (pick == 2) a = DEPTH * 4 + ($urandom % 256);
        else a = $urandom % (DEPTH * 4);
        sz = (pick == 3) ? 3'($urandom % 8) : 3'($urandom % 3);
        if (pick > 5 && sz != SZ_BYTE) a = a & ~((32'd1 << sz) - 1);
        xfer(a, 1'($urandom % 2), sz, $urandom);
      end
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule